// File: doc/BRIEF.md
# Two-Wire Keyboard Host Command Transmitter

This block is the host end of an open-drain, two-wire keyboard link, used to send one command byte to the keyboard. Both lines are wired-AND: the block never drives a line high. It only asserts a pull-down enable for each line, and it reads the resolved line levels back through a synchronizer. A send request in idle latches the byte, computes its parity and pulls the clock line low to claim the bus.

The keyboard answers by pulling the clock low itself and letting the data line rise. The host then lets go of the clock, and the keyboard generates every clock edge from that point on. On each rising clock edge the host presents the next bit: eight data bits least significant first, then an odd parity bit. The keyboard samples while the clock is low. After the ninth clock the host releases data for the stop phase and waits for the keyboard to pull data low as acknowledgment.

Every wait carries a timeout, counted in system clocks from a parameterized clocks-per-microsecond figure. On expiry the block releases both lines and reports an error. A one-cycle done pulse or error pulse ends each transfer, and a busy flag spans it.

Top module: `kbd_host_tx`

## Requirements
- R1: After reset both pull-down enables are off, and busy, done and error are all low.
- R2: A send request accepted in idle raises busy and the clock pull-down together. The clock pull-down stays on until the synchronized data line is high, then it is released, and it is never on while busy is low.
- R3: The eight data bits leave least significant bit first, one per keyboard rising clock edge. A bit value of 0 is sent by asserting the data pull-down and a 1 by releasing it. The data pull-down changes only while the clock line is high, except when a timeout releases it.
- R4: The ninth bit is odd parity: it is 1 when the byte has an even number of ones, so the nine bits together hold an odd count of ones.
- R5: On the tenth keyboard rising clock edge the host releases data. Done is reported only after the data line has been seen high and then pulled low by the keyboard.
- R6: If any wait (bus grant, start bit, next clock edge, stop level, acknowledgment) lasts CLKS_PER_US*TIMEOUT_US system clocks, the block releases both lines, pulses error and returns to idle. It does so no earlier than that count.
- R7: A send request while busy is ignored. The byte in flight is unchanged, and no second transfer follows.
- R8: Busy is high from the cycle after an accepted request until the cycle done or error pulses. Done and error are single-cycle pulses, never together, and never while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| send_i | input | 1 | Request to send data_i (accepted in idle only) |
| data_i | input | 8 | Command byte to send |
| kbd_clk_i | input | 1 | Resolved level of the link clock line |
| kbd_data_i | input | 1 | Resolved level of the link data line |
| clk_pull_o | output | 1 | Pull the clock line low when 1 |
| data_pull_o | output | 1 | Pull the data line low when 1 |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse: frame acknowledged |
| err_o | output | 1 | One-cycle pulse: a handshake wait timed out |

## Verification
The hardest states to reach from the ports are the timeouts that strike mid-frame and during the acknowledgment wait. A well-behaved keyboard never produces them. The bench keyboard model is therefore scripted to fall silent at chosen points: it ignores the request, freezes with the clock high after a few bits, or clocks a full frame and then withholds the acknowledgment. The bench checks that the error arrives no sooner than the timeout count and that the lines are released. A sweep over all 256 byte values then covers parity, bit order and the stop path, which differs by parity: after parity 0 the host's release is what raises the data line.

// File: rtl/kbd_tx_pkg.sv
package kbd_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_START,
    ST_SHIFT,
    ST_STOP_HI,
    ST_ACK
  } tx_state_e;

  // 1 when the byte holds an even number of ones
  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/kbd_tx_sync.sv
module kbd_tx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '1;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/kbd_tx_timer.sv
module kbd_tx_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/kbd_host_tx.sv
module kbd_host_tx
  import kbd_tx_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int TIMEOUT_US  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       send_i,
  input  logic [7:0] data_i,
  input  logic       kbd_clk_i,
  input  logic       kbd_data_i,
  output logic       clk_pull_o,
  output logic       data_pull_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  localparam int TIMEOUT_CYC = CLKS_PER_US * TIMEOUT_US;
  localparam int NBITS       = 9;
  localparam int IDX_W       = $clog2(NBITS + 1);

  tx_state_e          state_q;
  logic [NBITS-1:0]   frame_q;
  logic [IDX_W-1:0]   idx_q;
  logic               clk_pull_q, data_pull_q, done_q, err_q, clk_prev_q;
  logic               clk_s, data_s, clk_rise, step, expired;

  kbd_tx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({kbd_clk_i, kbd_data_i}),
    .q_o   ({clk_s, data_s})
  );

  assign clk_rise = clk_s & ~clk_prev_q;

  // one handshake wait satisfied this cycle
  always_comb begin
    unique case (state_q)
      ST_IDLE:    step = send_i;
      ST_REQ:     step = data_s;
      ST_START,
      ST_SHIFT:   step = clk_rise;
      ST_STOP_HI: step = data_s;
      ST_ACK:     step = ~data_s;
      default:    step = 1'b0;
    endcase
  end

  kbd_tx_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    ((state_q == ST_IDLE) | step),
    .expired_o(expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      frame_q     <= '0;
      idx_q       <= '0;
      clk_pull_q  <= 1'b0;
      data_pull_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      clk_prev_q  <= 1'b1;
    end else begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      clk_prev_q <= clk_s;
      if (state_q != ST_IDLE && expired) begin
        clk_pull_q  <= 1'b0;
        data_pull_q <= 1'b0;
        err_q       <= 1'b1;
        state_q     <= ST_IDLE;
      end else if (step) begin
        unique case (state_q)
          ST_IDLE: begin
            frame_q    <= {odd_par(data_i), data_i};
            idx_q      <= '0;
            clk_pull_q <= 1'b1;
            state_q    <= ST_REQ;
          end
          ST_REQ: begin
            clk_pull_q <= 1'b0;
            state_q    <= ST_START;
          end
          ST_START: begin
            data_pull_q <= ~frame_q[0];
            idx_q       <= IDX_W'(1);
            state_q     <= ST_SHIFT;
          end
          ST_SHIFT: begin
            if (idx_q == IDX_W'(NBITS)) begin
              data_pull_q <= 1'b0;
              state_q     <= ST_STOP_HI;
            end else begin
              data_pull_q <= ~frame_q[idx_q];
              idx_q       <= idx_q + 1'b1;
            end
          end
          ST_STOP_HI: state_q <= ST_ACK;
          ST_ACK: begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign clk_pull_o  = clk_pull_q;
  assign data_pull_o = data_pull_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/kbd_host_tx_chk.sv
module kbd_host_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic kbd_clk_i,
  input logic clk_pull_o,
  input logic data_pull_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  assert_req_clk_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> clk_pull_o);

  assert_clk_pull_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_pull_o |-> busy_o);

  assert_data_hi_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((data_pull_o != $past(data_pull_o)) && !err_o) |-> kbd_clk_i);

  assert_err_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!clk_pull_o && !data_pull_o && !busy_o));

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !err_o));

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> !(done_o || err_o));
endmodule

bind kbd_host_tx kbd_host_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .kbd_clk_i  (kbd_clk_i),
  .clk_pull_o (clk_pull_o),
  .data_pull_o(data_pull_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/kbd_host_tx_tb.sv
module kbd_host_tx_tb;
  localparam int CPU   = 2;
  localparam int TOUS  = 40;
  localparam int TOCYC = CPU * TOUS;
  localparam int HI    = 12;
  localparam int LO    = 6;
  localparam int STB   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic send = 1'b0;
  logic [7:0] din = '0;
  logic kb_clk_pull = 1'b0;
  logic kb_data_pull = 1'b1;
  logic clk_line, data_line;
  logic clk_pull_o, data_pull_o, busy_o, done_o, err_o;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign clk_line  = ~(clk_pull_o | kb_clk_pull);
  assign data_line = ~(data_pull_o | kb_data_pull);

  kbd_host_tx #(.CLKS_PER_US(CPU), .TIMEOUT_US(TOUS), .SYNC_STAGES(2)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .send_i     (send),
    .data_i     (din),
    .kbd_clk_i  (clk_line),
    .kbd_data_i (data_line),
    .clk_pull_o (clk_pull_o),
    .data_pull_o(data_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  always @(negedge clk) begin
    if (done_o) done_cnt++;
    if (err_o) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", cyc, 190000);
      summary();
    end
  end

  task automatic request(input logic [7:0] b);
    @(negedge clk); din = b; send = 1'b1;
    @(negedge clk); send = 1'b0; din = ~b;
  endtask

  // keyboard grants the bus; returns when host has released clock
  task automatic grant(output bit ok);
    int n;
    repeat (10) @(negedge clk);
    chk(clk_pull_o == 1'b1, "R2 clk held before data high", clk_pull_o, 1);
    kb_clk_pull = 1'b1;
    kb_data_pull = 1'b0;
    n = 0;
    while (clk_pull_o && n < 20) begin @(negedge clk); n++; end
    ok = !clk_pull_o;
    chk(ok, "R2 clk released after data high", clk_pull_o, 0);
  endtask

  // clock nbits bits, sampling each in the low phase
  task automatic clock_bits(input int nbits, output logic [8:0] rx);
    rx = '0;
    repeat (STB) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      kb_clk_pull = 1'b0;
      repeat (HI) @(negedge clk);
      kb_clk_pull = 1'b1;
      repeat (LO/2) @(negedge clk);
      rx[i] = data_line;
      repeat (LO - LO/2) @(negedge clk);
    end
  endtask

  task automatic frame(input logic [7:0] b, input bit poke);
    bit ok;
    logic [8:0] rx;
    int d0, n;
    d0 = done_cnt;
    request(b);
    chk(busy_o && clk_pull_o, "R2 busy and clk pull on accept", {busy_o, clk_pull_o}, 3);
    grant(ok);
    if (poke) begin
      @(negedge clk); din = 8'h3C; send = 1'b1;
      @(negedge clk); send = 1'b0;
    end
    clock_bits(9, rx);
    kb_clk_pull = 1'b0;
    repeat (HI) @(negedge clk);
    chk(data_line == 1'b1, "R5 stop level released", data_line, 1);
    chk(done_cnt == d0, "R5 no done before ack", done_cnt - d0, 0);
    chk(busy_o, "R8 busy until ack", busy_o, 1);
    chk(rx[7:0] == (poke ? 8'hA5 : b), "R3 data bits LSB first", rx[7:0], poke ? 8'hA5 : b);
    chk(rx[8] == ~^rx[7:0], "R4 odd parity bit", rx[8], ~^rx[7:0]);
    kb_data_pull = 1'b1;
    n = 0;
    while (done_cnt == d0 && n < 20) begin @(negedge clk); n++; end
    chk(done_cnt == d0 + 1, "R5 done after ack", done_cnt - d0, 1);
    chk(!busy_o, "R8 busy drops with done", busy_o, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_err(input string req, input int min_cyc);
    int e0, n;
    e0 = err_cnt;
    n = 0;
    while (err_cnt == e0 && n < 3*TOCYC) begin @(negedge clk); n++; end
    chk(err_cnt == e0 + 1, {req, " error pulse"}, err_cnt - e0, 1);
    chk(n >= min_cyc, {req, " not before timeout"}, n, min_cyc);
    chk(!clk_pull_o && !data_pull_o && !busy_o, {req, " lines released"},
        {clk_pull_o, data_pull_o, busy_o}, 0);
  endtask

  initial begin
    bit ok;
    logic [8:0] rx;
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({clk_pull_o, data_pull_o, busy_o, done_o, err_o} == 5'b0, "R1 reset outputs",
        {clk_pull_o, data_pull_o, busy_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({clk_pull_o, data_pull_o, busy_o} == 3'b0, "R1 idle after reset",
        {clk_pull_o, data_pull_o, busy_o}, 0);

    // R3 R4 R5: every byte value
    for (int v = 0; v < 256; v++) frame(8'(v), 1'b0);

    // R7 request while busy ignored
    frame(8'hA5, 1'b1);
    d0 = done_cnt;
    repeat (30) @(negedge clk);
    chk(!busy_o && !clk_pull_o, "R7 no second transfer", {busy_o, clk_pull_o}, 0);
    chk(done_cnt == d0, "R7 no extra done", done_cnt - d0, 0);

    // R6 keyboard ignores request
    request(8'h11);
    wait_err("R6 no grant", TOCYC - 4);

    // R6 keyboard stalls mid-frame with clock high
    request(8'h22);
    grant(ok);
    clock_bits(3, rx);
    kb_clk_pull = 1'b0;
    wait_err("R6 stalled clock", TOCYC - 4);
    kb_data_pull = 1'b1;
    repeat (5) @(negedge clk);

    // R6 no acknowledgment
    request(8'h33);
    grant(ok);
    clock_bits(9, rx);
    kb_clk_pull = 1'b0;
    wait_err("R6 no ack", TOCYC - 4);
    kb_data_pull = 1'b1;
    repeat (5) @(negedge clk);

    // recovery
    frame(8'h5A, 1'b0);

    finished = 1'b1;
    summary();
  end
endmodule